// File: doc/BRIEF.md
# Four-Level Priority Interrupt Controller

This block collects interrupt requests from three kinds of source and presents one winner at a time to a processor core. A small group of fixed sources (reset, stack fault, illegal opcode, debug, trap and a non-maskable line) always sits at level 3, the top level, which the core's mask can never block. Every other source has a two-bit priority code, set through a simple write port. The code both switches the source on and picks its level (0, 1 or 2). External pins are active low. Each pin passes through a two-stage synchronizer and can be set to level or falling-edge sensing.

Each cycle the controller drops every request whose level lies below the core's current mask level. Among the rest it picks the highest level, and on a tie the lowest slot. It then drives `irq_req`, the level and a vector address. The vector keeps the upper bits of a 256-word-aligned base and puts twice the winner's slot number in the low byte, so each slot holds two words. When the core pulses `ack` while a request is shown, the controller reports the level it served on the next cycle and clears the edge latch of the served pin.

Slot map: slots 0 to 5 are the fixed sources in the order reset, stack fault, illegal opcode, debug, trap, non-maskable line. Slots 6 and 7 are never requested. External pin e uses slot 8+e, and internal source j uses slot 8+NUM_EXT+j.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A programmable source with code 2'b00 never requests. Codes 2'b01, 2'b10 and 2'b11 give levels 0, 1 and 2 on `irq_lvl`.
- R2: A request is shown only when its level is greater than or equal to `core_mask`. Fixed sources are level 3 and pass every mask value.
- R3: Among the candidates the highest level wins. On a tie the lowest slot wins.
- R4: `irq_vec` equals {`vbase`[23:8], 2×slot}. Fixed slots give offsets 0x00, 0x02, 0x04, 0x06, 0x08 and 0x0A. External pin e gives 0x10+2e and internal source j gives 0x10+2·(NUM_EXT+j).
- R5: `vbase`[7:0] has no effect on `irq_vec`.
- R6: With trigger bit 0 (level), a low external pin requests two clock edges after it is driven low. The request drops two edges after the pin returns high.
- R7: With trigger bit 1 (edge), a high-to-low change of the pin sets a latch. The request then appears three edges after the falling drive and is held whatever the pin does afterwards. An `ack` that serves this pin clears the latch, and a pin that stays low does not set it again.
- R8: `ack` while `irq_req` is high gives `ack_vld`=1 on the next cycle, with `ack_lvl` equal to the level that was served. `ack` while `irq_req` is low gives `ack_vld`=0.
- R9: After reset all codes are 2'b00, all trigger bits are 0 and no latch is set, so no programmable source requests.
- R10: A write with `wr_en`=1 sets the code, and for external pins only the trigger bit, of the source at `wr_idx`. Here 0..NUM_EXT-1 select the pins and NUM_EXT.. select the internal sources. An index of NUM_EXT+NUM_INT or above changes nothing. For internal sources `wr_trig` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fix_req | input | 6 | Fixed level-3 request lines, slot order |
| ext_pin_n | input | NUM_EXT | Active-low external request pins |
| int_req | input | NUM_INT | On-chip level requests |
| wr_en | input | 1 | Configuration write strobe |
| wr_idx | input | $clog2(NUM_EXT+NUM_INT+1) | Programmable source index |
| wr_prio | input | 2 | Priority code to store |
| wr_trig | input | 1 | Trigger mode, 1 selects falling edge |
| vbase | input | 24 | Vector base address |
| core_mask | input | 2 | Current core mask level |
| irq_req | output | 1 | A request is presented |
| irq_vec | output | 24 | Vector address of the winner |
| irq_lvl | output | 2 | Level of the winner |
| ack | input | 1 | Core accepts the presented request |
| ack_vld | output | 1 | Served level is valid |
| ack_lvl | output | 2 | Level that was served |

## Verification
The hardest case is an edge latch meeting an acknowledge while its pin stays low. The latch must clear and stay clear with no new fall, and this only shows once the latch has won arbitration. It can only win when nothing of higher level or lower slot is pending at the same moment. The bench therefore clears every other code first and walks the pin through its synchronizer delay before it pulses `ack`. A long phase of random pins, masks, writes and acknowledges then meets the same corner with level-3 sources and mask changes in flight, and a behavioural model checks every cycle.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;
    localparam int NUM_FIXED   = 6;
    localparam int FIXED_SLOTS = 8;
    typedef logic [1:0] lvl_t;
    localparam lvl_t TOP_LVL = 2'd3;
endpackage

// File: rtl/irq_pin_cond.sv
`timescale 1ns/1ps
module irq_pin_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
        logic hit;
    } cond_t;

    cond_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.s1 = pin_n;
        nxt_d.s2 = cur_q.s1;
        nxt_d.s3 = cur_q.s2;
        if (edge_mode && cur_q.s3 && !cur_q.s2) begin
            nxt_d.hit = 1'b1;
        end else if (clr) begin
            nxt_d.hit = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{s1: 1'b1, s2: 1'b1, s3: 1'b1, hit: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign req = edge_mode ? cur_q.hit : !cur_q.s2;

    // R7: a set latch survives until the pin is served
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && cur_q.hit && !clr) |=> cur_q.hit);
endmodule

// File: rtl/irq_arbiter.sv
`timescale 1ns/1ps
module irq_arbiter
    import prio_irq_pkg::*;
#(
    parameter  int N_SRC = 16,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]       pend,
    input  lvl_t [N_SRC-1:0]       lvl,
    input  lvl_t                   mask,
    output logic                   found,
    output logic [IDX_W-1:0]       win_idx,
    output lvl_t                   win_lvl
);
    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        win_lvl = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (pend[i] && (lvl[i] >= mask) && (!found || (lvl[i] > win_lvl))) begin
                found   = 1'b1;
                win_idx = IDX_W'(i);
                win_lvl = lvl[i];
            end
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
    import prio_irq_pkg::*;
#(
    parameter  int NUM_EXT  = 4,
    parameter  int NUM_INT  = 4,
    parameter  int ADDR_W   = 24,
    localparam int NUM_PROG = NUM_EXT + NUM_INT,
    localparam int N_SRC    = FIXED_SLOTS + NUM_PROG,
    localparam int IDX_W    = $clog2(N_SRC),
    localparam int SEL_W    = $clog2(NUM_PROG + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FIXED-1:0] fix_req,
    input  logic [NUM_EXT-1:0]   ext_pin_n,
    input  logic [NUM_INT-1:0]   int_req,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_idx,
    input  logic [1:0]           wr_prio,
    input  logic                 wr_trig,
    input  logic [ADDR_W-1:0]    vbase,
    input  logic [1:0]           core_mask,
    output logic                 irq_req,
    output logic [ADDR_W-1:0]    irq_vec,
    output logic [1:0]           irq_lvl,
    input  logic                 ack,
    output logic                 ack_vld,
    output logic [1:0]           ack_lvl
);
    typedef struct packed {
        logic [NUM_PROG-1:0][1:0] prio;
        logic [NUM_EXT-1:0]       trig;
        logic                     served;
        lvl_t                     served_lvl;
    } ctrl_t;

    ctrl_t st_q, st_d;

    logic [NUM_PROG-1:0] raw_req;
    logic [N_SRC-1:0]    pend;
    lvl_t [N_SRC-1:0]    lvl;
    logic                found;
    logic [IDX_W-1:0]    win_idx;
    lvl_t                win_lvl;
    logic [6:0]          slot7;
    logic                unused_base_low;

    // External pin conditioning
    for (genvar e = 0; e < NUM_EXT; e++) begin : g_pin
        logic clr_e;
        assign clr_e = ack && found && (win_idx == IDX_W'(FIXED_SLOTS + e));
        irq_pin_cond u_cond (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_n    (ext_pin_n[e]),
            .edge_mode(st_q.trig[e]),
            .clr      (clr_e),
            .req      (raw_req[e])
        );
    end

    assign raw_req[NUM_PROG-1:NUM_EXT] = int_req;

    // Slot table: fixed, reserved, programmable
    for (genvar s = 0; s < N_SRC; s++) begin : g_slot
        if (s < NUM_FIXED) begin : g_fix
            assign pend[s] = fix_req[s];
            assign lvl[s]  = TOP_LVL;
        end else if (s < FIXED_SLOTS) begin : g_rsv
            assign pend[s] = 1'b0;
            assign lvl[s]  = TOP_LVL;
        end else begin : g_prog
            assign pend[s] = raw_req[s-FIXED_SLOTS] && (st_q.prio[s-FIXED_SLOTS] != 2'b00);
            assign lvl[s]  = lvl_t'(st_q.prio[s-FIXED_SLOTS] - 2'd1);
        end
    end

    irq_arbiter #(.N_SRC(N_SRC)) u_arb (
        .pend   (pend),
        .lvl    (lvl),
        .mask   (core_mask),
        .found  (found),
        .win_idx(win_idx),
        .win_lvl(win_lvl)
    );

    always_comb begin
        st_d        = st_q;
        st_d.served = ack && found;
        if (ack && found) begin
            st_d.served_lvl = win_lvl;
        end
        for (int p = 0; p < NUM_PROG; p++) begin
            if (wr_en && (wr_idx == SEL_W'(p))) begin
                st_d.prio[p] = wr_prio;
            end
        end
        for (int e = 0; e < NUM_EXT; e++) begin
            if (wr_en && (wr_idx == SEL_W'(e))) begin
                st_d.trig[e] = wr_trig;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot7           = 7'(win_idx);
    assign irq_req         = found;
    assign irq_lvl         = win_lvl;
    assign irq_vec         = {vbase[ADDR_W-1:8], slot7, 1'b0};
    assign ack_vld         = st_q.served;
    assign ack_lvl         = st_q.served_lvl;
    assign unused_base_low = ^vbase[7:0];

    // R2: nothing below the mask is ever presented
    a_r2_mask_respected: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl >= core_mask));

    // R4: the fixed slots always carry the top level
    a_r4_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && (irq_vec[7:0] < 8'h0C)) |-> (irq_lvl == 2'd3));

    // R1: programmable slots never reach level 3
    a_r1_prog_below_top: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && (irq_vec[7:0] >= 8'h10)) |-> (irq_lvl != 2'd3));

    // R8: an accepted request reports its level next cycle
    a_r8_served_level: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_req) |=> (ack_vld && (ack_lvl == $past(irq_lvl))));

    // R8: no report without an accepted request
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(ack && irq_req) |=> !ack_vld);
endmodule

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
    localparam int NE = 4;
    localparam int NI = 4;
    localparam int NP = NE + NI;
    localparam int AW = 24;
    localparam int SW = $clog2(NP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    fix_req = '0;
    logic [NE-1:0] ext_pin_n = '1;
    logic [NI-1:0] int_req = '0;
    logic          wr_en = 1'b0;
    logic [SW-1:0] wr_idx = '0;
    logic [1:0]    wr_prio = '0;
    logic          wr_trig = 1'b0;
    logic [AW-1:0] vbase = 24'h123400;
    logic [1:0]    core_mask = '0;
    logic          irq_req;
    logic [AW-1:0] irq_vec;
    logic [1:0]    irq_lvl;
    logic          ack = 1'b0;
    logic          ack_vld;
    logic [1:0]    ack_lvl;

    int    checks = 0;
    int    errors = 0;
    string cur_tag = "R9";

    always #4 clk = ~clk;

    prio_irq_ctrl #(.NUM_EXT(NE), .NUM_INT(NI), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .fix_req(fix_req), .ext_pin_n(ext_pin_n),
        .int_req(int_req), .wr_en(wr_en), .wr_idx(wr_idx), .wr_prio(wr_prio),
        .wr_trig(wr_trig), .vbase(vbase), .core_mask(core_mask),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
        .ack(ack), .ack_vld(ack_vld), .ack_lvl(ack_lvl)
    );

    // Behavioural reference model
    int mprio[NP];
    bit mtrig[NE];
    bit hist[NE][$];
    bit mlatch[NE];
    bit mav;
    int mal;

    function automatic bit pin_low_seen(int e);
        return hist[e][1] == 1'b0;
    endfunction

    function automatic void model_pick(output bit f, output int idx, output int lv);
        f = 0; idx = 0; lv = 0;
        for (int s = 0; s < 8 + NP; s++) begin
            bit p;
            int l;
            int k;
            p = 0; l = 0; k = s - 8;
            if (s < 6) begin
                p = fix_req[s]; l = 3;
            end else if (s >= 8 && mprio[k] != 0) begin
                l = mprio[k] - 1;
                if (k < NE) p = mtrig[k] ? mlatch[k] : pin_low_seen(k);
                else        p = int_req[k-NE];
            end
            if (p && l >= int'(core_mask) && (!f || l > lv)) begin
                f = 1; idx = s; lv = l;
            end
        end
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NP; p++) mprio[p] = 0;
            for (int e = 0; e < NE; e++) begin
                mtrig[e] = 0; mlatch[e] = 0; hist[e] = '{1'b1, 1'b1, 1'b1};
            end
            mav = 0; mal = 0;
        end else begin
            bit f;
            int idx;
            int lv;
            model_pick(f, idx, lv);
            for (int e = 0; e < NE; e++) begin
                if (mtrig[e] && hist[e][2] && !hist[e][1]) mlatch[e] = 1;
                else if (ack && f && idx == 8 + e) mlatch[e] = 0;
                hist[e].push_front(ext_pin_n[e]);
                void'(hist[e].pop_back());
            end
            mav = ack && f;
            if (mav) mal = lv;
            if (wr_en && int'(wr_idx) < NP) begin
                mprio[wr_idx] = wr_prio;
                if (int'(wr_idx) < NE) mtrig[wr_idx] = wr_trig;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            bit f;
            int idx;
            int lv;
            logic [AW-1:0] ev;
            model_pick(f, idx, lv);
            ev = {vbase[AW-1:8], 8'(idx * 2)};
            checks++;
            if (irq_req !== f || (f && (irq_vec !== ev || int'(irq_lvl) != lv))) begin
                errors++;
                $display("FAIL %s cycle compare: req=%0b vec=%h lvl=%0d exp req=%0b vec=%h lvl=%0d",
                         cur_tag, irq_req, irq_vec, irq_lvl, f, ev, lv);
            end
            checks++;
            if (ack_vld !== mav || (mav && int'(ack_lvl) != mal)) begin
                errors++;
                $display("FAIL R8 served report: vld=%0b lvl=%0d exp vld=%0b lvl=%0d",
                         ack_vld, ack_lvl, mav, mal);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic wr(int idx, int prio, bit trig);
        wr_en = 1; wr_idx = SW'(idx); wr_prio = 2'(prio); wr_trig = trig;
        tick(1);
        wr_en = 0;
    endtask

    task automatic pulse_ack();
        ack = 1;
        tick(1);
        ack = 0;
    endtask

    task automatic chk(bit ok, string tag, int got, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int_req = '1;
        ext_pin_n = '0;
        tick(3);
        rst_n = 1;
        tick(2);
        cur_tag = "R9";
        chk(irq_req == 0, "R9 no request after reset", irq_req, 0);
        ext_pin_n = '1;
        tick(3);

        cur_tag = "R1";
        wr(4, 1, 0);
        chk(irq_req && irq_lvl == 0, "R1 code 01 level", irq_lvl, 0);
        chk(irq_vec == 24'h123418, "R4 internal 0 vector", irq_vec, 24'h123418);
        wr(4, 2, 0);
        chk(irq_lvl == 1, "R1 code 10 level", irq_lvl, 1);
        wr(4, 3, 0);
        chk(irq_lvl == 2, "R1 code 11 level", irq_lvl, 2);
        wr(4, 0, 0);
        chk(irq_req == 0, "R1 code 00 disables", irq_req, 0);

        cur_tag = "R2";
        wr(4, 2, 0);
        core_mask = 2; #1;
        chk(irq_req == 0, "R2 level 1 masked by 2", irq_req, 0);
        core_mask = 1; #1;
        chk(irq_req == 1, "R2 level 1 passes mask 1", irq_req, 1);
        fix_req = 6'b100000; core_mask = 3; #1;
        chk(irq_req && irq_lvl == 3 && irq_vec[7:0] == 8'h0A, "R2 fixed passes mask 3",
            irq_vec[7:0], 8'h0A);
        tick(1);
        fix_req = '0; core_mask = 0;
        tick(1);

        cur_tag = "R3";
        wr(5, 2, 0);
        chk(irq_vec[7:0] == 8'h18, "R3 tie goes to lower slot", irq_vec[7:0], 8'h18);
        wr(6, 3, 0);
        chk(irq_vec[7:0] == 8'h1C && irq_lvl == 2, "R3 higher level wins", irq_vec[7:0], 8'h1C);
        fix_req = 6'b110000; #1;
        chk(irq_vec[7:0] == 8'h08, "R3 trap before non-maskable", irq_vec[7:0], 8'h08);
        tick(1);
        fix_req = '0;
        wr(5, 0, 0);
        wr(6, 0, 0);

        cur_tag = "R5";
        wr(4, 1, 0);
        vbase = 24'h5678FF; #1;
        chk(irq_vec == 24'h567818, "R5 low base bits ignored", irq_vec, 24'h567818);
        tick(1);
        vbase = 24'hABCD00;
        wr(4, 0, 0);

        cur_tag = "R6";
        wr(0, 3, 0);
        ext_pin_n[0] = 0;
        tick(1);
        chk(irq_req == 0, "R6 not yet through synchronizer", irq_req, 0);
        tick(1);
        chk(irq_req && irq_vec[7:0] == 8'h10 && irq_lvl == 2, "R6 level request",
            irq_vec[7:0], 8'h10);
        ext_pin_n[0] = 1;
        tick(2);
        chk(irq_req == 0, "R6 request follows pin high", irq_req, 0);
        wr(0, 0, 0);

        cur_tag = "R7";
        wr(1, 2, 1);
        ext_pin_n[1] = 0;
        tick(1);
        ext_pin_n[1] = 1;
        tick(2);
        chk(irq_req && irq_vec[7:0] == 8'h12 && irq_lvl == 1, "R7 edge latched",
            irq_vec[7:0], 8'h12);
        tick(5);
        chk(irq_req == 1, "R7 latch held with pin high", irq_req, 1);
        pulse_ack();
        chk(ack_vld && ack_lvl == 1, "R8 served level reported", ack_lvl, 1);
        chk(irq_req == 0, "R7 ack clears latch", irq_req, 0);
        ext_pin_n[1] = 0;
        tick(3);
        chk(irq_req == 1, "R7 second fall latched", irq_req, 1);
        pulse_ack();
        tick(4);
        chk(irq_req == 0, "R7 steady low does not relatch", irq_req, 0);
        ext_pin_n[1] = 1;
        wr(1, 0, 0);
        tick(3);

        cur_tag = "R8";
        pulse_ack();
        chk(ack_vld == 0, "R8 ack without request", ack_vld, 0);

        cur_tag = "R10";
        wr(NP + 4, 3, 0);
        chk(irq_req == 0, "R10 out-of-range write ignored", irq_req, 0);
        wr(4, 1, 1);
        int_req[0] = 0; #1;
        chk(irq_req == 0, "R10 trigger bit ignored for internal", irq_req, 0);
        int_req[0] = 1; #1;
        chk(irq_req == 1, "R10 internal follows input", irq_req, 1);
        tick(1);

        cur_tag = "R3";
        for (int c = 0; c < 4000; c++) begin
            fix_req   = ($urandom_range(0, 15) == 0) ? 6'($urandom) : 6'b0;
            int_req   = NI'($urandom);
            if ($urandom_range(0, 3) == 0) ext_pin_n = NE'($urandom);
            core_mask = ($urandom_range(0, 7) == 0) ? 2'($urandom) : 2'b0;
            ack       = $urandom_range(0, 2) == 0;
            vbase     = 24'($urandom);
            wr_en     = $urandom_range(0, 5) == 0;
            wr_idx    = SW'($urandom);
            wr_prio   = 2'($urandom);
            wr_trig   = 1'($urandom);
            tick(1);
        end
        wr_en = 0; ack = 0;
        tick(2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule